// File: doc/BRIEF.md
# Integer ALU with Signed and Unsigned Compares

This block is the integer execute unit of a small load/store RISC core. It is purely combinational. It takes two 32-bit operands, a 16-bit immediate with a flag that substitutes it for the second operand, a 5-bit shift amount and a 4-bit operation code. It returns a 32-bit result and a flag that is high whenever that result is zero.

Arithmetic wraps modulo 2^32 and never reports overflow. The two compare operations return the value 0 or 1. The unsigned compare can serve as a single-instruction bounds check: a negative index looks like a huge unsigned number, so it fails the test. Shifts always work on the second register operand, and the upper-immediate operation builds the top half of a constant that a following OR-immediate completes. Operand extension is handled inside the block. For the bitwise operations the immediate is zero-extended. For the arithmetic and compare operations it is sign-extended.

Top module: `alu_core`

## Requirements
- R1: Operation code 0 (add) returns src_a plus the second operand, modulo 2^32, with no overflow indication.
- R2: Operation code 1 (subtract) returns src_a minus the second operand, modulo 2^32.
- R3: Codes 2, 3 and 4 return the bitwise AND, OR and inverted OR (NOR) of src_a and the second operand.
- R4: Code 5 returns 32'd1 when src_a is less than the second operand as signed two's-complement numbers, else 32'd0.
- R5: Code 6 returns 32'd1 when src_a is less than the second operand as unsigned numbers, else 32'd0, so a negative src_a tested against a positive limit yields 0.
- R6: Code 7 shifts src_b left and code 8 shifts src_b right by shamt (0 to 31 places), filling vacated bits with zeros; a zero amount returns src_b unchanged.
- R7: Code 9 returns imm16 in bits 31:16 with bits 15:0 cleared, and an OR with imm_sel high on that value then yields the full 32-bit constant.
- R8: With imm_sel high, the second operand is imm16 zero-extended for codes 2, 3 and 4 and sign-extended for codes 0, 1, 5 and 6; with imm_sel low it is src_b.
- R9: The zero output is high exactly when result is all zeros, so subtracting equal operands raises it.
- R10: The unused codes 10 to 15 return 32'd0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 4 | Operation code (0 add, 1 sub, 2 and, 3 or, 4 nor, 5 signed less-than, 6 unsigned less-than, 7 shift left, 8 shift right, 9 upper immediate) |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand, also the value that shifts act on |
| imm16 | input | 16 | Instruction immediate |
| imm_sel | input | 1 | Use the extended immediate in place of src_b |
| shamt | input | 5 | Shift distance |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is zero |

## Verification
The embedded checks are immediate assertions evaluated after the combinational logic settles. Each one is gated on its inputs being known, so it assumes every input is a defined 0/1 value whenever it is evaluated. The bench meets that assumption by driving every port to a defined value before any comparison takes place. It changes all inputs together on the falling clock edge and draws every value, including out-of-range operation codes, from the full legal width of each port. This keeps the assertions on defined values throughout, while the undefined codes 10 to 15 are still reached.

// File: rtl/alu_pkg.sv
// Shared widths and the operation encoding for the integer ALU.
// Assumes a 32-bit datapath with a 16-bit instruction immediate.
package alu_pkg;
    localparam int XLEN  = 32;
    localparam int IMMW  = 16;
    localparam int SHW   = $clog2(XLEN);
    localparam int OPW   = 4;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_NOR  = 4'd4,
        OP_SLT  = 4'd5,
        OP_SLTU = 4'd6,
        OP_SLL  = 4'd7,
        OP_SRL  = 4'd8,
        OP_LUI  = 4'd9
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_NOR = 2'd2
    } logic_fn_e;
endpackage

// File: rtl/alu_imm_ext.sv
// Second-operand selector: passes the register operand or the immediate,
// extended by zeros or by its sign bit as the operation class requires.
// Assumes IW < W.
module alu_imm_ext #(
    parameter int W  = 32,
    parameter int IW = 16
) (
    input  logic [W-1:0]  reg_val,
    input  logic [IW-1:0] imm,
    input  logic          use_imm,
    input  logic          zext,
    output logic [W-1:0]  opnd
);
    localparam int PADW = W - IW;

    logic [W-1:0] imm_wide;

    // Widen the immediate by zero or by its sign bit.
    always_comb begin
        if (zext) imm_wide = {{PADW{1'b0}}, imm};
        else      imm_wide = {{PADW{imm[IW-1]}}, imm};
    end

    // Pick the operand that feeds the execute units.
    assign opnd = use_imm ? imm_wide : reg_val;

    // Extension checks against the raw immediate.
    always_comb begin
        if (!$isunknown({use_imm, zext, imm})) begin
            if (use_imm && zext)
                AST_ZEXT_UPPER: assert (opnd[W-1:IW] == '0); // R8
            if (use_imm && !zext)
                AST_SEXT_TOP: assert (opnd[W-1] == imm[IW-1] && opnd[IW-1:0] == imm); // R8
        end
    end
endmodule

// File: rtl/alu_addsub.sv
// Shared adder for add, subtract and both less-than compares.
// Subtract is a + ~b + 1; the carry out gives the unsigned borrow.
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         lt_s,
    output logic         lt_u
);
    logic [W:0]   wide;
    logic [W-1:0] b_in;

    // Invert the second operand for subtraction.
    assign b_in = sub ? ~b : b;

    // One carry chain with a spare top bit for the carry out.
    assign wide = {1'b0, a} + {1'b0, b_in} + {{W{1'b0}}, sub};
    assign sum  = wide[W-1:0];

    // No carry out of a - b means a borrow, i.e. a < b unsigned.
    assign lt_u = ~wide[W];

    // Signs differ: a is less exactly when it is negative; else use the difference sign.
    assign lt_s = (a[W-1] ^ b[W-1]) ? a[W-1] : wide[W-1];

    // Equal operands must subtract to zero and compare as not-less.
    always_comb begin
        if (!$isunknown({a, b, sub}) && sub && a == b)
            AST_SUB_EQUAL: assert (sum == '0 && !lt_u && !lt_s); // R2
    end
endmodule

// File: rtl/alu_logic.sv
// Bitwise unit: AND, OR and inverted OR of two operands.
module alu_logic #(
    parameter int W = 32
) (
    input  logic [W-1:0]      a,
    input  logic [W-1:0]      b,
    input  alu_pkg::logic_fn_e fn,
    output logic [W-1:0]      y
);
    import alu_pkg::*;

    // Select the bitwise function.
    always_comb begin
        unique case (fn)
            LG_AND:  y = a & b;
            LG_OR:   y = a | b;
            LG_NOR:  y = ~(a | b);
            default: y = '0;
        endcase
    end

    // NOR output never shares a set bit with either input.
    always_comb begin
        if (!$isunknown({a, b, fn}) && fn == LG_NOR)
            AST_NOR_DISJOINT: assert ((y & (a | b)) == '0); // R3
    end
endmodule

// File: rtl/alu_shift.sv
// Logical barrel shifter with zero fill. Left shifts reuse the
// right-shift stages by mirroring the bit order at input and output.
module alu_shift #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] amt,
    input  logic          left,
    output logic [W-1:0]  dout
);
    logic [W-1:0] stage [SW+1];
    logic [W-1:0] mirr_in;
    logic [W-1:0] res_r;

    // Mirror the operand for a left shift.
    for (genvar i = 0; i < W; i++) begin : g_mirror_in
        assign mirr_in[i] = left ? din[W-1-i] : din[i];
    end

    assign stage[0] = mirr_in;

    // Each stage moves by a power of two when its amount bit is set.
    for (genvar k = 0; k < SW; k++) begin : g_stage
        assign stage[k+1] = amt[k] ? (stage[k] >> (2**k)) : stage[k];
    end

    assign res_r = stage[SW];

    // Undo the mirror on the way out.
    for (genvar i = 0; i < W; i++) begin : g_mirror_out
        assign dout[i] = left ? res_r[W-1-i] : res_r[i];
    end

    // Zero distance is identity; nonzero distance empties the vacated end.
    always_comb begin
        if (!$isunknown({din, amt, left})) begin
            if (amt == '0)
                AST_SHIFT_IDENT: assert (dout == din); // R6
            if (amt != '0 && !left)
                AST_SRL_FILL: assert (dout[W-1] == 1'b0); // R6
            if (amt != '0 && left)
                AST_SLL_FILL: assert (dout[0] == 1'b0); // R6
        end
    end
endmodule

// File: rtl/alu_core.sv
// Integer ALU top: decodes the operation code, selects the second
// operand, runs the adder, bitwise and shift units and muxes one result.
// Purely combinational; assumes inputs are stable for one cycle.
module alu_core (
    input  logic [3:0]  op_sel,
    input  logic [31:0] src_a,
    input  logic [31:0] src_b,
    input  logic [15:0] imm16,
    input  logic        imm_sel,
    input  logic [4:0]  shamt,
    output logic [31:0] result,
    output logic        zero
);
    import alu_pkg::*;

    alu_op_e      op;
    logic         zext;
    logic         do_sub;
    logic [XLEN-1:0] opnd_b;
    logic [XLEN-1:0] sum;
    logic         lt_s;
    logic         lt_u;
    logic_fn_e    lfn;
    logic [XLEN-1:0] logic_y;
    logic [XLEN-1:0] shift_y;

    assign op = alu_op_e'(op_sel);

    // Operation class decode: extension kind, subtract mode, bitwise function.
    always_comb begin
        zext   = (op == OP_AND) || (op == OP_OR) || (op == OP_NOR);
        do_sub = (op == OP_SUB) || (op == OP_SLT) || (op == OP_SLTU);
        case (op)
            OP_OR:   lfn = LG_OR;
            OP_NOR:  lfn = LG_NOR;
            default: lfn = LG_AND;
        endcase
    end

    alu_imm_ext #(.W(XLEN), .IW(IMMW)) u_ext (
        .reg_val (src_b),
        .imm     (imm16),
        .use_imm (imm_sel),
        .zext    (zext),
        .opnd    (opnd_b)
    );

    alu_addsub #(.W(XLEN)) u_addsub (
        .a    (src_a),
        .b    (opnd_b),
        .sub  (do_sub),
        .sum  (sum),
        .lt_s (lt_s),
        .lt_u (lt_u)
    );

    alu_logic #(.W(XLEN)) u_logic (
        .a  (src_a),
        .b  (opnd_b),
        .fn (lfn),
        .y  (logic_y)
    );

    alu_shift #(.W(XLEN), .SW(SHW)) u_shift (
        .din  (src_b),
        .amt  (shamt),
        .left (op == OP_SLL),
        .dout (shift_y)
    );

    // Final result select by operation.
    always_comb begin
        case (op)
            OP_ADD, OP_SUB:        result = sum;
            OP_AND, OP_OR, OP_NOR: result = logic_y;
            OP_SLT:                result = {{(XLEN-1){1'b0}}, lt_s};
            OP_SLTU:               result = {{(XLEN-1){1'b0}}, lt_u};
            OP_SLL, OP_SRL:        result = shift_y;
            OP_LUI:                result = {imm16, {(XLEN-IMMW){1'b0}}};
            default:               result = '0;
        endcase
    end

    // Zero detect over the selected result.
    assign zero = ~|result;

    // Cross-unit checks on the final result.
    always_comb begin
        if (!$isunknown({op_sel, src_a, src_b, imm16, imm_sel, shamt})) begin
            if (op_sel == 4'd5)
                AST_SLT_BOOL: assert (result[XLEN-1:1] == '0); // R4
            if (op_sel == 4'd6)
                AST_SLTU_BOOL: assert (result[XLEN-1:1] == '0); // R5
            if (op_sel == 4'd9)
                AST_LUI_LOW: assert (result[XLEN-IMMW-1:0] == '0 && result[XLEN-1:XLEN-IMMW] == imm16); // R7
            if (op_sel == 4'd1 && src_a == opnd_b)
                AST_SUB_ZERO: assert (zero); // R9
            if (op_sel > 4'd9)
                AST_UNUSED_OP: assert (result == '0 && zero); // R10
        end
    end
endmodule

// File: tb/alu_core_tb.sv
`timescale 1ns/1ps
module alu_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_sel = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [15:0] imm16 = '0;
    logic        imm_sel = 1'b0;
    logic [4:0]  shamt = '0;
    logic [31:0] result;
    logic        zero;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    logic [31:0] last_res;

    always #2 clk = ~clk;

    alu_core dut_i (
        .op_sel (op_sel), .src_a (src_a), .src_b (src_b), .imm16 (imm16),
        .imm_sel (imm_sel), .shamt (shamt), .result (result), .zero (zero)
    );

    // Behavioural reference for one operation.
    function automatic logic [31:0] ref_model(input logic [3:0] op, input logic [31:0] a,
            input logic [31:0] b, input logic [15:0] im, input logic isel, input logic [4:0] sh);
        logic [31:0] bb;
        if (!isel)                       bb = b;
        else if (op >= 4'd2 && op <= 4'd4) bb = {16'h0, im};
        else                             bb = {{16{im[15]}}, im};
        case (op)
            4'd0: return a + bb;
            4'd1: return a - bb;
            4'd2: return a & bb;
            4'd3: return a | bb;
            4'd4: return ~(a | bb);
            4'd5: return ($signed(a) < $signed(bb)) ? 32'd1 : 32'd0;
            4'd6: return (a < bb) ? 32'd1 : 32'd0;
            4'd7: return b << sh;
            4'd8: return b >> sh;
            4'd9: return {im, 16'h0};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2, 4'd3, 4'd4: return "R3";
            4'd5: return "R4";
            4'd6: return "R5";
            4'd7, 4'd8: return "R6";
            4'd9: return "R7";
            default: return "R10";
        endcase
    endfunction

    // Apply one vector on the falling edge and compare shortly after.
    task automatic run(input string req, input logic [3:0] op, input logic [31:0] a,
            input logic [31:0] b, input logic [15:0] im, input logic isel, input logic [4:0] sh);
        logic [31:0] exp_r;
        @(negedge clk);
        op_sel = op; src_a = a; src_b = b; imm16 = im; imm_sel = isel; shamt = sh;
        #1;
        exp_r = ref_model(op, a, b, im, isel, sh);
        total++;
        if (result !== exp_r) begin
            bad++;
            $display("FAIL %s op=%0d result actual=%h expected=%h", req, op, result, exp_r);
        end
        total++;
        if (zero !== (exp_r == 32'd0)) begin
            bad++;
            $display("FAIL R9 (%s) zero actual=%b expected=%b", req, zero, exp_r == 32'd0);
        end
        last_res = result;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle inputs: add of zeros gives zero with flag set.
        run("R1", 4'd0, 32'h0, 32'h0, 16'h0, 1'b0, 5'd0);
        // R1 wrap
        run("R1", 4'd0, 32'hFFFF_FFFF, 32'h1, 16'h0, 1'b0, 5'd0);
        run("R1", 4'd0, 32'h7FFF_FFFF, 32'h1, 16'h0, 1'b0, 5'd0);
        // R2 wrap and equal operands (R9)
        run("R2", 4'd1, 32'h0, 32'h1, 16'h0, 1'b0, 5'd0);
        run("R9", 4'd1, 32'h1234_5678, 32'h1234_5678, 16'h0, 1'b0, 5'd0);
        // R3 bitwise
        run("R3", 4'd2, 32'hF0F0_1234, 32'hFF00_FF00, 16'h0, 1'b0, 5'd0);
        run("R3", 4'd3, 32'hF0F0_1234, 32'h0F00_00FF, 16'h0, 1'b0, 5'd0);
        run("R3", 4'd4, 32'h0000_FFFF, 32'hFFFF_0000, 16'h0, 1'b0, 5'd0);
        run("R3", 4'd4, 32'h1, 32'h0, 16'h0, 1'b0, 5'd0);
        // R4 signed compare
        run("R4", 4'd5, 32'hFFFF_FFFF, 32'h1, 16'h0, 1'b0, 5'd0);
        run("R4", 4'd5, 32'h1, 32'hFFFF_FFFF, 16'h0, 1'b0, 5'd0);
        run("R4", 4'd5, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 1'b0, 5'd0);
        // R5 unsigned compare as bounds check
        run("R5", 4'd6, 32'hFFFF_FFFF, 32'd10, 16'h0, 1'b0, 5'd0);
        run("R5", 4'd6, 32'd3, 32'd10, 16'h0, 1'b0, 5'd0);
        run("R5", 4'd6, 32'd10, 32'd10, 16'h0, 1'b0, 5'd0);
        // R6 shifts, full range and zero distance
        run("R6", 4'd7, 32'h0, 32'h8000_0001, 16'h0, 1'b0, 5'd31);
        run("R6", 4'd8, 32'h0, 32'h8000_0001, 16'h0, 1'b0, 5'd31);
        run("R6", 4'd8, 32'h0, 32'hDEAD_BEEF, 16'h0, 1'b0, 5'd0);
        run("R6", 4'd7, 32'h0, 32'hDEAD_BEEF, 16'h0, 1'b0, 5'd4);
        // R7 upper immediate, then OR-immediate completes the constant
        run("R7", 4'd9, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hAAAA, 1'b0, 5'd7);
        run("R7", 4'd3, last_res, 32'h0, 16'h5555, 1'b1, 5'd0);
        total++;
        if (last_res !== 32'hAAAA_5555) begin
            bad++;
            $display("FAIL R7 constant actual=%h expected=%h", last_res, 32'hAAAA_5555);
        end
        // R8 extension by class
        run("R8", 4'd2, 32'hFFFF_FFFF, 32'h0, 16'hFF00, 1'b1, 5'd0);
        run("R8", 4'd4, 32'h0, 32'h0, 16'h8000, 1'b1, 5'd0);
        run("R8", 4'd0, 32'd8, 32'h0, 16'hFFFC, 1'b1, 5'd0);
        run("R8", 4'd5, 32'd0, 32'h0, 16'hFFFF, 1'b1, 5'd0);
        run("R8", 4'd6, 32'd5, 32'h0, 16'hFFFF, 1'b1, 5'd0);
        // R10 unused codes
        run("R10", 4'd12, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'hFFFF, 1'b1, 5'd3);
        run("R10", 4'd15, 32'h1, 32'h2, 16'h3, 1'b0, 5'd1);
        // Mixed random sweep over every code
        for (int n = 0; n < 3000; n++) begin
            logic [3:0]  rop;
            logic [31:0] ra;
            logic [31:0] rb;
            rop = 4'($urandom_range(0, 15));
            ra  = $urandom();
            rb  = (n % 7 == 0) ? ra : $urandom();
            run(tag_of(rop), rop, ra, rb, 16'($urandom()), 1'($urandom()), 5'($urandom()));
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4.0 * 200000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule